// File: doc/BRIEF.md
# Chained Serializer Readout Controller

This block is the host side of a serial link to a chain of eight-input industrial serializers. The chips are wired in a daisy chain and all shift out within one chip-select frame. On a one-cycle start pulse the controller lowers chip select and clocks the whole chain in SPI mode 0, most significant bit first. There are two word formats. In the wide format each chip sends an input byte and then a status byte. In the narrow format each chip sends only its input byte.

When the frame ends, the block decodes every chip separately. It checks a five-bit CRC over the input byte and reads the temperature and supply bits of the status byte. It also samples a fault line, which is either shared by the whole chain or given one per chip. A chip found faulting has its inputs forced to zero and its valid bit cleared. Healthy chips in the same chain still deliver their data. The flat input vector, the valid vector and the diagnostic vectors all change together, in the cycle a one-cycle done pulse is raised.

Top module: `serin_chain_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, done is low, and every input, valid and diagnostic bit is zero.
- R2: A start pulse opens one frame. Chip select goes low, then the serial clock gives exactly N_CHIPS×16 rising edges in the wide format (mode8=0) or N_CHIPS×8 in the narrow format (mode8=1). Each edge sits CLK_DIV cycles after the previous level change, and the clock is low whenever chip select is high.
- R3: Bits arrive most significant bit first. The first byte received belongs to chip 0. Chip i's input byte is byte i×W of the frame (W=2 wide, W=1 narrow). In the wide format the status byte follows it directly. Chip i's inputs appear on inputs[8i+7:8i], with input bit k on bit 8i+k.
- R4: In the wide format, status bits [7:3] are compared with the remainder of (input byte × x^5) divided by x^5+x^4+x^2+1, taken most significant bit first from a zero start. A mismatch sets crc_err[i].
- R5: In the wide format, status bit 1 high sets overtemp[i], status bit 2 low sets uv_alarm[i], and status bit 0 low sets uv_warn[i].
- R6: A chip is faulting if its fault line is high, or if it has a CRC error, overtemperature or an undervoltage alarm. An undervoltage warning alone leaves the chip valid.
- R7: With ignore_uv high, uv_alarm, uv_warn and fault_seen read zero and take no part in the faulting decision. CRC and overtemperature still count.
- R8: With FAULT_LINES=1, the single fault line applies to every chip. With FAULT_LINES=N_CHIPS, fault_in[i] applies to chip i only. fault_seen[i] shows the line a chip used.
- R9: In the narrow format, crc_err, overtemp, uv_alarm and uv_warn read zero, and only the fault line can mark a chip faulting.
- R10: A faulting chip has valid[i]=0 and its eight input bits forced to zero. Every other chip shows its received byte.
- R11: Done is a one-cycle pulse, high in the cycle after the last serial falling edge, and chip select is high again in that cycle. All output vectors take their new values in that same cycle and hold otherwise.
- R12: A start pulse that arrives during a frame is ignored. The frame's timing is unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to read the chain |
| mode8 | input | 1 | 1 = input byte only, 0 = input plus status byte; taken at start |
| ignore_uv | input | 1 | Exclude supply bits and fault line from the decision; taken at the end of the frame |
| fault_in | input | FAULT_LINES | Fault line(s), already synchronised |
| spi_miso | input | 1 | Serial data from the chain |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when the outputs update |
| inputs | output | N_CHIPS×8 | Input bits, faulting chips forced to zero |
| valid | output | N_CHIPS | Chip not faulting |
| crc_err | output | N_CHIPS | CRC mismatch per chip |
| overtemp | output | N_CHIPS | Overtemperature per chip |
| uv_alarm | output | N_CHIPS | Undervoltage alarm per chip |
| uv_warn | output | N_CHIPS | Undervoltage warning per chip |
| fault_seen | output | N_CHIPS | Fault line seen per chip |

## Verification
The hardest case to reach is a chain where different chips fail for different reasons in the same frame. One chip has a bad CRC or overtemperature, another has an undervoltage alarm, and a third has only a warning, and masking must still keep each chip apart. The bench's chain model serves a frame of bytes picked per chip, with the CRC bits computed by polynomial long division and then corrupted or left intact on purpose. A reference model predicts every output on every cycle.

A second instance uses one shared fault line and the same serial data, so both sharing variants are seen on the same frame. Another frame sends a second start pulse in the middle of the transfer to reach the busy case.

// File: rtl/serin_pkg.sv
// Shared types and the CRC function for the chained serializer reader.
// Assumes: CRC generator x^5+x^4+x^2+1 over one byte, MSB first, zero start.
package serin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_FINISH
    } rx_state_t;

    typedef struct packed {
        logic crc_err;
        logic overtemp;
        logic uv_alarm;
        logic uv_warn;
        logic fault;
    } chip_diag_t;

    // Five-bit check value of one input byte, via an 8-bit MSB-aligned register.
    function automatic logic [4:0] crc5_of(input logic [7:0] d);
        logic [7:0] r;
        r = d;
        for (int k = 0; k < 8; k++) begin
            r = r[7] ? ((r << 1) ^ 8'hA8) : (r << 1);
        end
        return r[7:3];
    endfunction

endpackage

// File: rtl/serin_spi_rx.sv
// SPI mode 0 receive engine. It lowers chip select, toggles the serial clock
// every CLK_DIV cycles, samples MISO on each rising edge into one shift register
// that holds the whole frame, and flags the cycle after the last falling edge.
// Assumes: the chain changes MISO on falling edges; mode is fixed at start.
module serin_spi_rx
    import serin_pkg::*;
#(
    parameter int N_CHIPS = 3,
    parameter int CLK_DIV = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   mode8,
    input  logic                   spi_miso,
    output logic                   spi_sclk,
    output logic                   spi_cs_n,
    output logic                   busy,
    output logic                   frame_end,
    output logic                   mode8_q,
    output logic [N_CHIPS*16-1:0]  frame
);
    localparam int FW    = N_CHIPS * 16;
    localparam int CNT_W = $clog2(CLK_DIV + 1);
    localparam int BIT_W = $clog2(FW + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CLK_DIV - 1);
    localparam logic [BIT_W-1:0] LAST16  = BIT_W'(FW - 1);
    localparam logic [BIT_W-1:0] LAST8   = BIT_W'(N_CHIPS * 8 - 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitcnt;
    logic [BIT_W-1:0]  last_bit;

    // Index of the final bit for the format chosen at start.
    always_comb last_bit = mode8_q ? LAST8 : LAST16;

    // Frame sequencer: divider, clock toggling, sampling and bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            spi_sclk <= 1'b0;
            spi_cs_n <= 1'b1;
            cnt      <= '0;
            bitcnt   <= '0;
            mode8_q  <= 1'b0;
            frame    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_XFER;
                        spi_cs_n <= 1'b0;
                        cnt      <= '0;
                        bitcnt   <= '0;
                        mode8_q  <= mode8;
                        frame    <= '0;
                    end
                end
                ST_XFER: begin
                    if (cnt == CNT_TOP) begin
                        cnt <= '0;
                        if (!spi_sclk) begin
                            spi_sclk <= 1'b1;
                            frame    <= {frame[FW-2:0], spi_miso};
                        end else begin
                            spi_sclk <= 1'b0;
                            if (bitcnt == last_bit) begin
                                state <= ST_FINISH;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FINISH: begin
                    spi_cs_n <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Status decode for the top level.
    always_comb begin
        busy      = (state != ST_IDLE);
        frame_end = (state == ST_FINISH);
    end

    // Mode 0: the serial clock never leaves idle while deselected.
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // A start seen while a frame runs does not restart the frame.
    assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_end && start) |=> !spi_cs_n);

endmodule

// File: rtl/serin_chip_diag.sv
// Per-chip decoder: checks the CRC, decodes the status bits (some active low),
// applies the ignore option and fault line, and masks the inputs of a faulting chip.
// Assumes: the bytes are stable while the result is captured; purely combinational.
module serin_chip_diag
    import serin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode8,
    input  logic        ignore_uv,
    input  logic [7:0]  in_byte,
    input  logic [7:0]  status_byte,
    input  logic        fault_line,
    output chip_diag_t  diag,
    output logic        healthy,
    output logic [7:0]  masked
);
    logic wide;

    // Decode flags and the faulting decision for one chip.
    always_comb begin
        wide          = !mode8;
        diag.crc_err  = wide && (status_byte[7:3] != crc5_of(in_byte));
        diag.overtemp = wide && status_byte[1];
        diag.uv_alarm = wide && !ignore_uv && !status_byte[2];
        diag.uv_warn  = wide && !ignore_uv && !status_byte[0];
        diag.fault    = !ignore_uv && fault_line;
        healthy       = !(diag.crc_err || diag.overtemp || diag.uv_alarm || diag.fault);
        masked        = healthy ? in_byte : 8'h00;
    end

    // A warning on its own keeps the chip usable.
    assert_warn_alone_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (diag.uv_warn && !diag.uv_alarm && !diag.crc_err && !diag.overtemp && !diag.fault)
        |-> healthy);

    // Narrow format carries no status byte.
    assert_narrow_no_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode8 |-> !(diag.crc_err || diag.overtemp || diag.uv_alarm || diag.uv_warn));

    // Ignored supply bits and fault line never show.
    assert_ignore_uv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ignore_uv |-> !(diag.uv_alarm || diag.uv_warn || diag.fault));

endmodule

// File: rtl/serin_chain_reader.sv
// Top of the chained serializer reader. It runs one SPI frame per start pulse,
// splits the frame into per-chip bytes, decodes each chip, and registers every
// output vector in one cycle together with a done pulse.
// Assumes: fault_in is synchronised; ignore_uv and fault_in are sampled at capture.
module serin_chain_reader
    import serin_pkg::*;
#(
    parameter int N_CHIPS     = 3,
    parameter int CLK_DIV     = 2,
    parameter int FAULT_LINES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  mode8,
    input  logic                  ignore_uv,
    input  logic [FAULT_LINES-1:0] fault_in,
    input  logic                  spi_miso,
    output logic                  spi_sclk,
    output logic                  spi_cs_n,
    output logic                  busy,
    output logic                  done,
    output logic [N_CHIPS*8-1:0]  inputs,
    output logic [N_CHIPS-1:0]    valid,
    output logic [N_CHIPS-1:0]    crc_err,
    output logic [N_CHIPS-1:0]    overtemp,
    output logic [N_CHIPS-1:0]    uv_alarm,
    output logic [N_CHIPS-1:0]    uv_warn,
    output logic [N_CHIPS-1:0]    fault_seen
);
    localparam int FW = N_CHIPS * 16;
    localparam int NW = N_CHIPS * 8;

    logic                 frame_end;
    logic                 mode8_q;
    logic [FW-1:0]        frame;
    logic [NW-1:0]        nxt_inputs;
    logic [N_CHIPS-1:0]   nxt_valid;
    chip_diag_t           nxt_diag [N_CHIPS];

    serin_spi_rx #(
        .N_CHIPS (N_CHIPS),
        .CLK_DIV (CLK_DIV)
    ) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode8     (mode8),
        .spi_miso  (spi_miso),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .busy      (busy),
        .frame_end (frame_end),
        .mode8_q   (mode8_q),
        .frame     (frame)
    );

    for (genvar i = 0; i < N_CHIPS; i++) begin : g_chip
        logic [7:0] in_byte;
        logic [7:0] st_byte;
        logic       fline;

        // Pick chip i's bytes: first received byte sits highest in the frame.
        always_comb begin
            st_byte = frame[FW-9-16*i -: 8];
            in_byte = mode8_q ? frame[NW-1-8*i -: 8] : frame[FW-1-16*i -: 8];
        end

        if (FAULT_LINES == 1) begin : g_shared
            assign fline = fault_in[0];
        end else begin : g_own
            assign fline = fault_in[i];
        end

        serin_chip_diag i_diag (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode8       (mode8_q),
            .ignore_uv   (ignore_uv),
            .in_byte     (in_byte),
            .status_byte (st_byte),
            .fault_line  (fline),
            .diag        (nxt_diag[i]),
            .healthy     (nxt_valid[i]),
            .masked      (nxt_inputs[8*i +: 8])
        );
    end

    // Capture all result vectors together and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            inputs     <= '0;
            valid      <= '0;
            crc_err    <= '0;
            overtemp   <= '0;
            uv_alarm   <= '0;
            uv_warn    <= '0;
            fault_seen <= '0;
        end else begin
            done <= frame_end;
            if (frame_end) begin
                inputs <= nxt_inputs;
                valid  <= nxt_valid;
                for (int i = 0; i < N_CHIPS; i++) begin
                    crc_err[i]    <= nxt_diag[i].crc_err;
                    overtemp[i]   <= nxt_diag[i].overtemp;
                    uv_alarm[i]   <= nxt_diag[i].uv_alarm;
                    uv_warn[i]    <= nxt_diag[i].uv_warn;
                    fault_seen[i] <= nxt_diag[i].fault;
                end
            end
        end
    end

    // Done lasts one cycle.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Outputs only move at capture.
    assert_outputs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(valid) && $stable(inputs) && $stable(crc_err)));

    // Done arrives with chip select already released.
    assert_done_cs_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);

    for (genvar i = 0; i < N_CHIPS; i++) begin : g_chk
        // Withheld chips show no input bits.
        assert_masked_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !valid[i] |-> (inputs[8*i +: 8] == 8'h00));
    end

endmodule

// File: tb/test_serin_chain_reader.sv
module test_serin_chain_reader;
    localparam int N   = 3;
    localparam int DIV = 2;
    localparam int FB  = N * 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode8 = 1'b0;
    logic ign = 1'b0;
    logic [N-1:0] flt = '0;
    logic shf = 1'b0;
    logic spi_miso;
    logic spi_sclk, spi_cs_n, busy, done;
    logic [N*8-1:0] inputs;
    logic [N-1:0] valid, crc_err, overtemp, uv_alarm, uv_warn, fault_seen;
    logic sh_sclk, sh_cs_n, sh_busy, sh_done;
    logic [N*8-1:0] sh_inputs;
    logic [N-1:0] sh_valid, sh_crc, sh_ot, sh_uva, sh_uvw, sh_flt;

    int checks = 0;
    int errors = 0;
    int idx = 0;
    int rises = 0;
    bit finished = 0;
    logic [FB-1:0] fr = '0;
    logic [7:0] dat [N];
    logic [7:0] sta [N];

    // expected outputs
    logic [N*8-1:0] e_in = '0;
    logic [N-1:0] e_v = '0, e_ce = '0, e_ot = '0, e_ua = '0, e_uw = '0, e_fs = '0, e_sv = '0;

    always #10 clk = ~clk;

    serin_chain_reader #(.N_CHIPS(N), .CLK_DIV(DIV), .FAULT_LINES(N)) i_serin_chain_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .mode8(mode8), .ignore_uv(ign),
        .fault_in(flt), .spi_miso(spi_miso), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .busy(busy), .done(done), .inputs(inputs), .valid(valid), .crc_err(crc_err),
        .overtemp(overtemp), .uv_alarm(uv_alarm), .uv_warn(uv_warn), .fault_seen(fault_seen));

    serin_chain_reader #(.N_CHIPS(N), .CLK_DIV(DIV), .FAULT_LINES(1)) i_serin_chain_reader_shared (
        .clk(clk), .rst_n(rst_n), .start(start), .mode8(mode8), .ignore_uv(ign),
        .fault_in(shf), .spi_miso(spi_miso), .spi_sclk(sh_sclk), .spi_cs_n(sh_cs_n),
        .busy(sh_busy), .done(sh_done), .inputs(sh_inputs), .valid(sh_valid), .crc_err(sh_crc),
        .overtemp(sh_ot), .uv_alarm(sh_uva), .uv_warn(sh_uvw), .fault_seen(sh_flt));

    // chain model: next bit on each falling serial edge, rewind when deselected
    always @(negedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) idx = 0;
        else idx = idx + 1;
    end
    assign spi_miso = (idx < FB) ? fr[FB-1-idx] : 1'b0;

    always @(posedge spi_sclk) rises = rises + 1;

    function automatic logic [4:0] ref_crc(input logic [7:0] d);
        logic [12:0] v;
        v = {d, 5'b0};
        for (int b = 12; b >= 5; b--) begin
            if (v[b]) v = v ^ (13'b110101 << (b - 5));
        end
        return v[4:0];
    endfunction

    function automatic logic [7:0] good_st(input logic [7:0] d);
        return {ref_crc(d), 3'b101};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one frame, compared against the model on every cycle
    task automatic run_frame(input string req, input bit extra_start);
        int pos;
        int nbits;
        int fin;
        logic [N*8-1:0] n_in;
        logic [N-1:0] n_v, n_ce, n_ot, n_ua, n_uw, n_fs, n_sv;
        pos = FB - 1;
        fr = '0;
        for (int i = 0; i < N; i++) begin
            for (int b = 7; b >= 0; b--) begin fr[pos] = dat[i][b]; pos--; end
            if (!mode8) begin
                for (int b = 7; b >= 0; b--) begin fr[pos] = sta[i][b]; pos--; end
            end
        end
        for (int i = 0; i < N; i++) begin
            logic ce, ot, ua, uw, fl, fls;
            ce = !mode8 && (sta[i][7:3] != ref_crc(dat[i]));
            ot = !mode8 && sta[i][1];
            ua = !mode8 && !ign && !sta[i][2];
            uw = !mode8 && !ign && !sta[i][0];
            fl = !ign && flt[i];
            fls = !ign && shf;
            n_ce[i] = ce; n_ot[i] = ot; n_ua[i] = ua; n_uw[i] = uw; n_fs[i] = fl;
            n_v[i] = !(ce || ot || ua || fl);
            n_sv[i] = !(ce || ot || ua || fls);
            n_in[8*i +: 8] = n_v[i] ? dat[i] : 8'h00;
        end
        nbits = mode8 ? N * 8 : N * 16;
        fin = 2 * DIV * nbits + 1;
        rises = 0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= fin + 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (extra_start && k == 10) start = 1'b1;
            else start = 1'b0;
            if (k == fin) begin
                e_in = n_in; e_v = n_v; e_ce = n_ce; e_ot = n_ot;
                e_ua = n_ua; e_uw = n_uw; e_fs = n_fs; e_sv = n_sv;
            end
            // R11: done pulse, release of chip select and output hold/update
            chk("R11", "done/cs_n", {62'd0, done, spi_cs_n}, {62'd0, k == fin, k >= fin});
            chk(req, "outputs",
                {inputs, valid, crc_err, overtemp, uv_alarm, uv_warn, fault_seen},
                {e_in, e_v, e_ce, e_ot, e_ua, e_uw, e_fs});
        end
        chk("R2", "serial clock edges", 64'(rises), 64'(nbits));
        chk("R8", "shared fault valid", {61'd0, sh_valid}, {61'd0, e_sv});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "idle pins", {61'd0, spi_cs_n, spi_sclk, done}, {61'd0, 1'b1, 1'b0, 1'b0});
        chk("R1", "outputs zero", {inputs, valid, crc_err, overtemp, uv_alarm, uv_warn, fault_seen}, '0);

        // R3: healthy chain, byte ordering
        dat[0] = 8'hA5; dat[1] = 8'h3C; dat[2] = 8'hF0;
        for (int i = 0; i < N; i++) sta[i] = good_st(dat[i]);
        run_frame("R3", 0);
        chk("R3", "chip order", {40'd0, inputs}, {40'd0, 8'hF0, 8'h3C, 8'hA5});

        // R4: CRC mismatch on chip 1
        dat[0] = 8'h01; dat[1] = 8'h80; dat[2] = 8'h7E;
        for (int i = 0; i < N; i++) sta[i] = good_st(dat[i]);
        sta[1] = sta[1] ^ 8'h08;
        run_frame("R4", 0);
        chk("R4", "crc flag", {61'd0, crc_err}, {61'd0, 3'b010});

        // R5/R6: overtemp chip 0, uv alarm chip 1, warning only chip 2
        for (int i = 0; i < N; i++) sta[i] = good_st(dat[i]);
        sta[0] = sta[0] | 8'h02;
        sta[1] = sta[1] & 8'hFB;
        sta[2] = sta[2] & 8'hFE;
        run_frame("R5", 0);
        chk("R6", "warning alone valid", {61'd0, valid}, {61'd0, 3'b100});

        // R7: ignore option with fault line on chip 1
        ign = 1'b1; flt = 3'b010; shf = 1'b1;
        run_frame("R7", 0);
        chk("R7", "ignore keeps chips valid", {61'd0, valid}, {61'd0, 3'b110});

        // R8/R10: per-chip fault on chip 2, shared line high
        ign = 1'b0; flt = 3'b100; shf = 1'b1;
        for (int i = 0; i < N; i++) sta[i] = good_st(dat[i]);
        run_frame("R10", 0);
        chk("R10", "masked chip", {40'd0, inputs}, {40'd0, 8'h00, 8'h80, 8'h01});

        // R9: narrow format, fault on chip 1
        mode8 = 1'b1; flt = 3'b010; shf = 1'b0;
        dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h33;
        run_frame("R9", 0);
        chk("R9", "narrow fault", {61'd0, fault_seen}, {61'd0, 3'b010});

        // R12: second start during the frame is ignored
        mode8 = 1'b0; flt = '0;
        dat[0] = 8'hC3; dat[1] = 8'h00; dat[2] = 8'hFF;
        for (int i = 0; i < N; i++) sta[i] = good_st(dat[i]);
        run_frame("R12", 1);
        chk("R12", "no second frame", {62'd0, spi_cs_n, busy}, {62'd0, 1'b1, 1'b0});

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule